// File: doc/BRIEF.md
# Allocation Tag Load Unit

This block decodes and runs one instruction: a load of a 4-bit allocation tag. It takes a 32-bit instruction word together with a valid strobe. Inside it holds a 32-entry file of 64-bit general registers, where entry 31 is the stack pointer when it serves as a base. It also holds a tag store with one 4-bit tag for each 16-byte granule. The unit adds a signed 9-bit immediate, scaled by 16, to the base register. It aligns the sum down to a granule boundary and reads the tag that covers that granule. It then splices the tag into bits 59:56 of the destination register. All other destination bits keep their old value.

The unit takes two cycles per instruction. In the first cycle it decodes the word, generates the address and registers it. In the second it reads the tag, merges it and writes the register back, and a done pulse with the result follows. A word that fails to decode raises an illegal flag. A misaligned stack pointer used as base raises an alignment fault. In both cases the register file is left alone.

Two load ports let a test environment preload registers and tags, and a peek port reads any register. An instruction may follow the previous one on the very next cycle. A base register that the previous instruction is about to write is forwarded from the merge path. The unit has no condition flags, so it changes none.

Top module: `tag_load_unit`

## Requirements
- R1: A word is decoded as the tag load when its bits 31:21 equal 11011001011 and its bits 11:10 equal 00. Any other word raises `illegal` together with `done` and writes no register.
- R2: Field positions: bits 20:12 hold the signed 9-bit immediate, bits 9:5 hold the base register index, and bits 4:0 hold the destination register index.
- R3: The lookup address is base + (sign-extended immediate × 16) with bits 3:0 cleared. It is reported on `lookup_addr`, and the tag store entry at address bits 11:4 is read. Low bits of a general base register do not change the granule chosen.
- R4: A base index of 31 selects the stack pointer (register entry 31). If that value has any of bits 3:0 set, `align_fault` rises with `done`, and neither `wb_en` nor a register write happens.
- R5: The result equals the previous destination value with bits 59:56 replaced by the 4-bit tag. It is written to the destination register and reported on `wb_data` and `wb_idx` with `wb_en` high.
- R6: A destination index of 31 discards the result. `wb_en` stays low, no register entry changes, and `wb_data` holds the tag in bits 59:56 with every other bit zero.
- R7: `done` is a one-cycle pulse two clock edges after the edge that samples `instr_valid`, for every accepted word, and it accompanies `wb_en`, `illegal` and `align_fault`.
- R8: Back to back: an instruction issued on the cycle after one that writes register r, and that uses r as its base, sees the newly merged value.
- R9: After reset, `done`, `wb_en`, `illegal` and `align_fault` are low.
- R10: A write through the tag load port replaces the tag that later lookups of that granule return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| rf_load_en | input | 1 | Preload write enable for the register file |
| rf_load_idx | input | 5 | Preload register index |
| rf_load_data | input | 64 | Preload register value |
| rf_peek_idx | input | 5 | Register index to observe |
| rf_peek_data | output | 64 | Current value of the observed register |
| tag_load_en | input | 1 | Tag store write enable |
| tag_load_idx | input | 8 | Granule index to write |
| tag_load_data | input | 4 | Tag value to write |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| wb_en | output | 1 | Result was written to a register |
| wb_idx | output | 5 | Destination index of the completed instruction |
| wb_data | output | 64 | Merged result |
| lookup_addr | output | 64 | Granule-aligned address used for the tag lookup |
| illegal | output | 1 | Completed word did not decode |
| align_fault | output | 1 | Stack pointer base was not granule aligned |

## Verification
A wrong tag store entry or a bad address sum shows at the ports on the first `done` that touches it. It appears as a wrong `lookup_addr` or as a wrong nibble in `wb_data` bits 59:56. A damaged register entry, or a wrongly suppressed or spurious write, stays hidden until a later instruction uses that entry as base or destination, or until the peek port reads it. For that reason the peek port is read after every completed instruction. A fault in the forwarding path shows only in the second of two back-to-back instructions, one cycle after the first result.

// File: rtl/tlu_pkg.sv
package tlu_pkg;

  localparam int INSN_W    = 32;
  localparam int REG_IDX_W = 5;
  localparam int IMM_W     = 9;

  // fixed opcode bits: 31:21 and 11:10
  localparam logic [INSN_W-1:0] OPC_MASK = 32'hFFE0_0C00;
  localparam logic [INSN_W-1:0] OPC_VAL  = 32'hD960_0000;

  localparam logic [REG_IDX_W-1:0] SP_IDX = '1;

  typedef struct packed {
    logic                 hit;
    logic [IMM_W-1:0]     imm;
    logic [REG_IDX_W-1:0] base;
    logic [REG_IDX_W-1:0] dst;
  } dec_t;

endpackage

// File: rtl/tlu_rst_sync.sv
module tlu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/tlu_decode.sv
module tlu_decode
  import tlu_pkg::*;
(
  input  logic [INSN_W-1:0] instr,
  output dec_t              dec
);

  always_comb begin
    dec.hit  = ((instr & OPC_MASK) == OPC_VAL);
    dec.imm  = instr[20:12];
    dec.base = instr[9:5];
    dec.dst  = instr[4:0];
  end

endmodule

// File: rtl/tlu_agu.sv
module tlu_agu
  import tlu_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int GRAN_LG2 = 4
) (
  input  logic [XLEN-GRAN_LG2-1:0] base_hi,
  input  logic [IMM_W-1:0]         imm,
  output logic [XLEN-1:0]          addr_aligned
);

  localparam int HI_W  = XLEN - GRAN_LG2;
  localparam int EXT_W = HI_W - IMM_W;

  logic [HI_W-1:0] imm_ext;
  logic [HI_W-1:0] sum_hi;

  // the scaled offset has zero low bits, so the granule number is
  // the sum of the upper base bits and the sign-extended immediate
  always_comb begin
    imm_ext      = {{EXT_W{imm[IMM_W-1]}}, imm};
    sum_hi       = base_hi + imm_ext;
    addr_aligned = {sum_hi, {GRAN_LG2{1'b0}}};
  end

endmodule

// File: rtl/tlu_regfile.sv
module tlu_regfile
  import tlu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 32
) (
  input  logic                 clk,
  input  logic                 wb_we,
  input  logic [REG_IDX_W-1:0] wb_idx,
  input  logic [XLEN-1:0]      wb_data,
  input  logic                 ld_we,
  input  logic [REG_IDX_W-1:0] ld_idx,
  input  logic [XLEN-1:0]      ld_data,
  input  logic [REG_IDX_W-1:0] base_idx,
  output logic [XLEN-1:0]      base_data,
  input  logic [REG_IDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]      dst_data,
  input  logic [REG_IDX_W-1:0] peek_idx,
  output logic [XLEN-1:0]      peek_data
);

  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    logic            wb_sel;
    logic            ld_sel;
    logic            en;
    logic [XLEN-1:0] nxt;

    always_comb begin
      wb_sel = wb_we && (wb_idx == REG_IDX_W'(g));
      ld_sel = ld_we && (ld_idx == REG_IDX_W'(g));
      en     = wb_sel || ld_sel;
      nxt    = wb_sel ? wb_data : ld_data;   // pipeline write wins
    end

    always_ff @(posedge clk) begin
      if (en) begin
        regs[g] <= nxt;
      end
    end
  end

  assign base_data = regs[base_idx];
  assign dst_data  = regs[dst_idx];
  assign peek_data = regs[peek_idx];

endmodule

// File: rtl/tlu_tag_store.sv
module tlu_tag_store #(
  parameter int TAG_W = 4,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);

  localparam int DEPTH = 1 << IDX_W;

  logic [TAG_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[wr_idx] <= wr_tag;
    end
  end

  assign rd_tag = mem[rd_idx];

endmodule

// File: rtl/tag_load_unit.sv
module tag_load_unit
  import tlu_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int NREG     = 32,
  parameter int TAG_W    = 4,
  parameter int TAG_LSB  = 56,
  parameter int GRAN_LG2 = 4,
  parameter int TIDX_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 instr_valid,
  input  logic [INSN_W-1:0]    instr,
  input  logic                 rf_load_en,
  input  logic [REG_IDX_W-1:0] rf_load_idx,
  input  logic [XLEN-1:0]      rf_load_data,
  input  logic [REG_IDX_W-1:0] rf_peek_idx,
  output logic [XLEN-1:0]      rf_peek_data,
  input  logic                 tag_load_en,
  input  logic [TIDX_W-1:0]    tag_load_idx,
  input  logic [TAG_W-1:0]     tag_load_data,
  output logic                 done,
  output logic                 wb_en,
  output logic [REG_IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]      wb_data,
  output logic [XLEN-1:0]      lookup_addr,
  output logic                 illegal,
  output logic                 align_fault
);

  localparam int              HI_W     = XLEN - GRAN_LG2;
  localparam logic [XLEN-1:0] TAG_MASK = XLEN'({TAG_W{1'b1}}) << TAG_LSB;

  logic rst_i_n;

  tlu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // ---------------- stage 1: decode and address ----------------
  dec_t            dec;
  logic [XLEN-1:0] rf_base;
  logic [XLEN-1:0] rf_dst;
  logic [XLEN-1:0] base_val;
  logic [XLEN-1:0] addr_aligned;
  logic            fwd_hit;
  logic            sp_misal;

  logic                 s1_valid_q, s1_valid_d;
  logic                 s1_illegal_q, s1_illegal_d;
  logic                 s1_fault_q, s1_fault_d;
  logic [REG_IDX_W-1:0] s1_dst_q, s1_dst_d;
  logic [XLEN-1:0]      s1_addr_q, s1_addr_d;
  logic                 s1_load;

  // stage 2 signals used by forwarding
  logic            s2_wr;
  logic [XLEN-1:0] merged;

  tlu_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  always_comb begin
    fwd_hit  = s2_wr && (s1_dst_q == dec.base);
    base_val = fwd_hit ? merged : rf_base;
    sp_misal = (dec.base == SP_IDX) && (base_val[GRAN_LG2-1:0] != '0);
  end

  tlu_agu #(
    .XLEN     (XLEN),
    .GRAN_LG2 (GRAN_LG2)
  ) u_agu (
    .base_hi      (base_val[XLEN-1:GRAN_LG2]),
    .imm          (dec.imm),
    .addr_aligned (addr_aligned)
  );

  always_comb begin
    s1_valid_d   = instr_valid;
    s1_load      = instr_valid;
    s1_illegal_d = !dec.hit;
    s1_fault_d   = dec.hit && sp_misal;
    s1_dst_d     = dec.dst;
    s1_addr_d    = addr_aligned;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_load) begin
      s1_illegal_q <= s1_illegal_d;
      s1_fault_q   <= s1_fault_d;
      s1_dst_q     <= s1_dst_d;
      s1_addr_q    <= s1_addr_d;
    end
  end

  // ---------------- stage 2: tag read, merge, writeback ----------------
  logic [TAG_W-1:0] tag_rd;
  logic [XLEN-1:0]  old_val;
  logic             s2_ok;

  tlu_tag_store #(
    .TAG_W (TAG_W),
    .IDX_W (TIDX_W)
  ) u_tags (
    .clk    (clk),
    .we     (tag_load_en),
    .wr_idx (tag_load_idx),
    .wr_tag (tag_load_data),
    .rd_idx (s1_addr_q[GRAN_LG2 +: TIDX_W]),
    .rd_tag (tag_rd)
  );

  always_comb begin
    s2_ok   = s1_valid_q && !s1_illegal_q && !s1_fault_q;
    s2_wr   = s2_ok && (s1_dst_q != SP_IDX);
    old_val = (s1_dst_q == SP_IDX) ? '0 : rf_dst;
    merged  = (old_val & ~TAG_MASK) | (XLEN'(tag_rd) << TAG_LSB);
  end

  tlu_regfile #(
    .XLEN (XLEN),
    .NREG (NREG)
  ) u_rf (
    .clk       (clk),
    .wb_we     (s2_wr),
    .wb_idx    (s1_dst_q),
    .wb_data   (merged),
    .ld_we     (rf_load_en),
    .ld_idx    (rf_load_idx),
    .ld_data   (rf_load_data),
    .base_idx  (dec.base),
    .base_data (rf_base),
    .dst_idx   (s1_dst_q),
    .dst_data  (rf_dst),
    .peek_idx  (rf_peek_idx),
    .peek_data (rf_peek_data)
  );

  // ---------------- result registers ----------------
  logic                 done_q, done_d;
  logic                 wb_en_q, wb_en_d;
  logic                 ill_q, ill_d;
  logic                 flt_q, flt_d;
  logic [REG_IDX_W-1:0] wb_idx_q;
  logic [XLEN-1:0]      wb_data_q;
  logic [XLEN-1:0]      laddr_q;

  always_comb begin
    done_d  = s1_valid_q;
    wb_en_d = s2_wr;
    ill_d   = s1_valid_q && s1_illegal_q;
    flt_d   = s1_valid_q && !s1_illegal_q && s1_fault_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      done_q  <= 1'b0;
      wb_en_q <= 1'b0;
      ill_q   <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      done_q  <= done_d;
      wb_en_q <= wb_en_d;
      ill_q   <= ill_d;
      flt_q   <= flt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid_q) begin
      wb_idx_q  <= s1_dst_q;
      wb_data_q <= merged;
      laddr_q   <= s1_addr_q;
    end
  end

  assign done        = done_q;
  assign wb_en       = wb_en_q;
  assign illegal     = ill_q;
  assign align_fault = flt_q;
  assign wb_idx      = wb_idx_q;
  assign wb_data     = wb_data_q;
  assign lookup_addr = laddr_q;

endmodule

// File: rtl/tag_load_unit_chk.sv
module tag_load_unit_chk
  import tlu_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 instr_valid,
  input logic                 done,
  input logic                 wb_en,
  input logic [REG_IDX_W-1:0] wb_idx,
  input logic [63:0]          wb_data,
  input logic [63:0]          lookup_addr,
  input logic                 illegal,
  input logic                 align_fault
);

  // R7: every accepted word completes two edges later
  a_r7_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |-> ##2 done);

  // R7: status outputs only appear with done
  a_r7_status_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || illegal || align_fault) |-> done);

  // R1, R4: at most one outcome per completion
  a_r1_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, illegal, align_fault}));

  // R6: discarded result carries only the tag nibble
  a_r6_zero_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal && !align_fault && (wb_idx == SP_IDX))
      |-> (!wb_en && (wb_data[55:0] == '0) && (wb_data[63:60] == '0)));

  // R3: lookup address is granule aligned on every completion
  a_r3_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> (lookup_addr[3:0] == 4'h0));

  // R7: done is a single-cycle pulse unless words arrive back to back
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !instr_valid) |=> ##1 !done);

endmodule

bind tag_load_unit tag_load_unit_chk u_chk (.*);

// File: tb/tag_load_unit_tb.sv
module tag_load_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr;
  logic        rf_load_en;
  logic [4:0]  rf_load_idx;
  logic [63:0] rf_load_data;
  logic [4:0]  rf_peek_idx;
  logic [63:0] rf_peek_data;
  logic        tag_load_en;
  logic [7:0]  tag_load_idx;
  logic [3:0]  tag_load_data;
  logic        done;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic [63:0] lookup_addr;
  logic        illegal;
  logic        align_fault;

  tag_load_unit u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .instr_valid   (instr_valid),
    .instr         (instr),
    .rf_load_en    (rf_load_en),
    .rf_load_idx   (rf_load_idx),
    .rf_load_data  (rf_load_data),
    .rf_peek_idx   (rf_peek_idx),
    .rf_peek_data  (rf_peek_data),
    .tag_load_en   (tag_load_en),
    .tag_load_idx  (tag_load_idx),
    .tag_load_data (tag_load_data),
    .done          (done),
    .wb_en         (wb_en),
    .wb_idx        (wb_idx),
    .wb_data       (wb_data),
    .lookup_addr   (lookup_addr),
    .illegal       (illegal),
    .align_fault   (align_fault)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] m_rf  [32];
  logic [3:0]  m_tag [256];

  localparam logic [63:0] SP_BASE = 64'h0000_7FFF_FFFF_F000;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [8:0] imm, input logic [4:0] n,
                                      input logic [4:0] t);
    return 32'hD960_0000 | {11'b0, imm, 2'b00, n, t};
  endfunction

  function automatic logic [63:0] gaddr(input logic [63:0] base, input logic [8:0] imm);
    logic [63:0] off;
    off = {{51{imm[8]}}, imm, 4'b0000};
    return (base + off) & ~64'hF;
  endfunction

  function automatic logic [63:0] splice(input logic [63:0] old, input logic [3:0] tg);
    return (old & ~(64'hF << 56)) | ({60'b0, tg} << 56);
  endfunction

  task automatic load_reg(input logic [4:0] idx, input logic [63:0] val);
    @(negedge clk);
    rf_load_en   = 1'b1;
    rf_load_idx  = idx;
    rf_load_data = val;
    @(negedge clk);
    rf_load_en   = 1'b0;
    m_rf[idx]    = val;
  endtask

  task automatic load_tag(input logic [7:0] idx, input logic [3:0] val);
    @(negedge clk);
    tag_load_en   = 1'b1;
    tag_load_idx  = idx;
    tag_load_data = val;
    @(negedge clk);
    tag_load_en   = 1'b0;
    m_tag[idx]    = val;
  endtask

  // drive one word; return at the negedge where the result is visible
  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    instr_valid = 1'b1;
    instr       = w;
    @(negedge clk);
    instr_valid = 1'b0;
    @(negedge clk);
  endtask

  // run a legal tag load (SP base must be aligned) and check everything
  task automatic run_ok(input logic [8:0] imm, input logic [4:0] n, input logic [4:0] t,
                        input string req);
    logic [63:0] a;
    logic [63:0] exp;
    logic [63:0] keep;
    a    = gaddr(m_rf[n], imm);
    exp  = splice((t == 5'd31) ? 64'h0 : m_rf[t], m_tag[a[11:4]]);
    keep = m_rf[t];
    rf_peek_idx = t;
    issue(enc(imm, n, t));
    chk(done == 1'b1, {req, " R7 done"}, {63'b0, done}, 64'h1);
    chk(lookup_addr == a, {req, " R3 addr"}, lookup_addr, a);
    chk(wb_data == exp, {req, " R5 data"}, wb_data, exp);
    if (t == 5'd31) begin
      chk(wb_en == 1'b0, {req, " R6 no wb_en"}, {63'b0, wb_en}, 64'h0);
      chk(rf_peek_data == keep, {req, " R6 sp kept"}, rf_peek_data, keep);
    end else begin
      chk(wb_en == 1'b1 && wb_idx == t, {req, " R5 wb_en"}, {58'b0, wb_en, wb_idx},
          {58'b0, 1'b1, t});
      chk(rf_peek_data == exp, {req, " R5 reg"}, rf_peek_data, exp);
      m_rf[t] = exp;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n         = 1'b0;
    instr_valid   = 1'b0;
    instr         = '0;
    rf_load_en    = 1'b0;
    rf_load_idx   = '0;
    rf_load_data  = '0;
    rf_peek_idx   = '0;
    tag_load_en   = 1'b0;
    tag_load_idx  = '0;
    tag_load_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 reset state
    chk(done == 1'b0, "R9 done", {63'b0, done}, 64'h0);
    chk(wb_en == 1'b0, "R9 wb_en", {63'b0, wb_en}, 64'h0);
    chk(illegal == 1'b0, "R9 illegal", {63'b0, illegal}, 64'h0);
    chk(align_fault == 1'b0, "R9 align_fault", {63'b0, align_fault}, 64'h0);

    for (int i = 0; i < 256; i++) load_tag(8'(i), 4'((i * 7 + 3) & 15));
    for (int i = 0; i < 31; i++) load_reg(5'(i), 64'h0123_4567_89AB_CDE7 ^ (64'(i) * 64'h1111_0000_0101_0010));
    load_reg(5'd31, SP_BASE);

    // R2 R3 R5: all 512 immediates from a general base with low bits set
    for (int k = 0; k < 512; k++) run_ok(9'(k), 5'd1, 5'(2 + (k % 28)), "R2 R3 imm sweep");

    // R4: every base index, stack pointer aligned
    for (int b = 0; b < 32; b++) run_ok(9'd3, 5'(b), 5'd30, "R4 base sweep");

    // R6: destination 31 discards the result
    run_ok(9'h1F5, 5'd2, 5'd31, "R6 zero dest");

    // R10: rewrite a tag and read it back
    begin
      logic [63:0] a;
      a = gaddr(m_rf[3], 9'd9);
      load_tag(a[11:4], ~m_tag[a[11:4]]);
      run_ok(9'd9, 5'd3, 5'd8, "R10 tag rewrite");
    end

    // R4: misaligned stack pointer faults and writes nothing
    for (int nib = 1; nib < 16; nib++) begin
      logic [63:0] keep;
      load_reg(5'd31, SP_BASE | 64'(nib));
      keep = m_rf[4];
      rf_peek_idx = 5'd4;
      issue(enc(9'd0, 5'd31, 5'd4));
      chk(done && align_fault && !wb_en && !illegal, "R4 fault flag",
          {60'b0, done, align_fault, wb_en, illegal}, 64'hC);
      chk(rf_peek_data == keep, "R4 no write", rf_peek_data, keep);
    end
    load_reg(5'd31, SP_BASE);

    // R1: every fixed bit flipped gives illegal
    begin
      int fixed_bits [13] = '{31, 30, 29, 28, 27, 26, 25, 24, 23, 22, 21, 11, 10};
      for (int j = 0; j < 13; j++) begin
        logic [63:0] keep;
        keep = m_rf[5];
        rf_peek_idx = 5'd5;
        issue(enc(9'd1, 5'd1, 5'd5) ^ (32'h1 << fixed_bits[j]));
        chk(done && illegal && !wb_en && !align_fault, "R1 illegal flag",
            {60'b0, done, illegal, wb_en, align_fault}, 64'hC);
        chk(rf_peek_data == keep, "R1 no write", rf_peek_data, keep);
      end
    end

    // R8: back-to-back with dependent base
    begin
      logic [63:0] a1, e1, a2, e2;
      a1 = gaddr(m_rf[1], 9'd2);
      e1 = splice(m_rf[6], m_tag[a1[11:4]]);
      m_rf[6] = e1;
      a2 = gaddr(m_rf[6], 9'h1FF);
      e2 = splice(m_rf[7], m_tag[a2[11:4]]);
      m_rf[7] = e2;
      @(negedge clk);
      instr_valid = 1'b1;
      instr       = enc(9'd2, 5'd1, 5'd6);
      @(negedge clk);
      instr       = enc(9'h1FF, 5'd6, 5'd7);
      @(negedge clk);
      instr_valid = 1'b0;
      chk(done && wb_en && wb_data == e1, "R8 first", wb_data, e1);
      @(negedge clk);
      chk(lookup_addr == a2, "R8 fwd addr", lookup_addr, a2);
      chk(done && wb_en && wb_data == e2, "R8 second", wb_data, e2);
      rf_peek_idx = 5'd7;
      #1;
      chk(rf_peek_data == e2, "R8 reg", rf_peek_data, e2);
    end

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule